// File: doc/BRIEF.md
# Guarded instruction predecoder

This block takes one 24-bit word from the instruction stream that the control processor and the processing-element array share, and decides whether the unit it serves executes the word or treats it as a no-operation. A role input tells the block whether it serves the control processor or a processing element. A target bit in the word picks which side the word belongs to. A guard bit picks one of two cases: the word runs unconditionally, or it runs only when a local condition flag is set. The block splits out the opcode, the three register addresses and the immediate. It then turns the opcode class into one-hot execution strobes: register write, memory write, send, receive and flag update. A suppressed word raises none of them.

The flag sits inside the block. The execution stage writes it through a small update port, and the flag-update strobe tells that stage when an executed compare wants the flag rewritten. On the control-processor side the block also evaluates the exit test of a receive block. A loop-check opcode repeats while any lane still reports a message in flight. It exits once every lane is quiet. In frame-synchronising mode it also waits until every lane reports its column done.

Top module: `gpd_top`

## Requirements
- R1: `dec_strobe` is high in exactly the cycle after a cycle with `instr_valid` high. After a cycle without `instr_valid`, all strobe and enable outputs are low.
- R2: Bit 23 of the word is the target bit (1 = processing-element word, 0 = control-processor word). A word executes only when this bit equals `role_pe`.
- R3: Bit 22 is the guard bit. When it is 1, a word with a matching target executes. When it is 0, the word executes only if the flag held at the cycle the word is sampled is 1.
- R4: The flag resets to 0 and appears on `flag_q`. A write through `flag_wr_en`/`flag_wr_val` first affects words sampled in the following cycle. A word sampled in the same cycle as the write sees the old value.
- R5: The opcode is bits 21:16, rA is bits 15:12, rB is bits 11:8 and rC is bits 7:4. They are reported with the strobe whether or not the word executes.
- R6: Opcodes 0x10 to 0x1F are immediate-form. For these, `dec_imm` is bits 7:0, `dec_imm_form` is 1 and `dec_rc` reads 0. For every other opcode, `dec_imm` reads 0.
- R7: An executed word raises exactly one class strobe, or none. Opcodes 0x01 to 0x1F raise `reg_we`, 0x20 raises `mem_we`, 0x21 raises `send_stb`, 0x22 raises `recv_stb` and 0x23 raises `flag_upd`. All other opcodes raise none.
- R8: A word that does not execute raises no class strobe and no loop output, and reports `dec_exec` = 0.
- R9: An executed loop-check word (opcode 0x30) with `role_pe` = 0 raises `loop_repeat` if any `pend_vec` bit is set. Otherwise it raises `loop_exit` if `sync_mode` is 0 or every `done_vec` bit is 1, and otherwise `loop_repeat`. The two outputs are never high together. On the processing-element side, opcode 0x30 raises neither.
- R10: During and right after reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| role_pe | input | 1 | 1: serves a processing element, 0: serves the control processor |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr | input | 24 | Instruction word |
| flag_wr_en | input | 1 | Write the local condition flag |
| flag_wr_val | input | 1 | Value written to the flag |
| pend_vec | input | N_LANES | Per-lane message-in-flight bits |
| done_vec | input | N_LANES | Per-lane column-done bits |
| sync_mode | input | 1 | Loop exit also needs every done bit |
| dec_strobe | output | 1 | Decoded outputs valid |
| dec_exec | output | 1 | Decoded word executes |
| dec_opcode | output | 6 | Opcode field |
| dec_ra | output | 4 | Register address A |
| dec_rb | output | 4 | Register address B |
| dec_rc | output | 4 | Register address C (0 in immediate form) |
| dec_imm | output | 8 | Immediate (0 outside immediate form) |
| dec_imm_form | output | 1 | Opcode is immediate-form |
| reg_we | output | 1 | Register write strobe |
| mem_we | output | 1 | Memory write strobe |
| send_stb | output | 1 | Send strobe |
| recv_stb | output | 1 | Receive strobe |
| flag_upd | output | 1 | Flag-update request strobe |
| loop_repeat | output | 1 | Receive block must repeat |
| loop_exit | output | 1 | Receive block may exit |
| flag_q | output | 1 | Current local flag |

## Verification
Every decoded output, including the execute decision and both loop outputs, is due one clock edge after the word is presented. A flag write shows up on `flag_q` one edge later and governs only the words sampled after that edge. The bench drives each stimulus on a falling edge and compares on the next falling edge, so exactly one rising edge lies between stimulus and check. The same-cycle flag write is checked over two consecutive words to pin down which flag value the guard uses.

// File: rtl/gpd_pkg.sv
// Package: shared instruction layout, opcode values and decode records
// for the guarded instruction predecoder.
// Assumes a fixed 24-bit word; bit positions are decoded by neighbours.
package gpd_pkg;
    localparam int INSTR_W = 24;
    localparam int OPC_W   = 6;
    localparam int RADDR_W = 4;
    localparam int IMM_W   = 8;

    localparam int ID_BIT  = 23;
    localparam int G_BIT   = 22;
    localparam int OPC_LSB = 16;
    localparam int RA_LSB  = 12;
    localparam int RB_LSB  = 8;
    localparam int RC_LSB  = 4;

    localparam logic [OPC_W-1:0] OP_STORE = 6'h20;
    localparam logic [OPC_W-1:0] OP_SEND  = 6'h21;
    localparam logic [OPC_W-1:0] OP_RECV  = 6'h22;
    localparam logic [OPC_W-1:0] OP_CMPF  = 6'h23;
    localparam logic [OPC_W-1:0] OP_RLOOP = 6'h30;

    typedef struct packed {
        logic               id;
        logic               g;
        logic [OPC_W-1:0]   opc;
        logic [RADDR_W-1:0] ra;
        logic [RADDR_W-1:0] rb;
        logic [RADDR_W-1:0] rc;
        logic [IMM_W-1:0]   imm;
        logic               imm_form;
    } fields_t;

    typedef struct packed {
        logic reg_we;
        logic mem_we;
        logic send;
        logic recv;
        logic flag_upd;
        logic rloop;
    } ctl_t;
endpackage

// File: rtl/gpd_field_split.sv
// Module: gpd_field_split
// Purely combinational split of one instruction word into its fields and
// its opcode class. Assumes the package layout; no execution decision here.
module gpd_field_split
    import gpd_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output fields_t            fld,
    output ctl_t               cls
);
    logic [OPC_W-1:0] opc;
    logic             imm_form;

    assign opc      = instr[OPC_LSB +: OPC_W];
    assign imm_form = (opc[OPC_W-1:OPC_W-2] == 2'b01);

    // Field extraction; immediate replaces rC and the reserved nibble.
    always_comb begin
        fld.id       = instr[ID_BIT];
        fld.g        = instr[G_BIT];
        fld.opc      = opc;
        fld.ra       = instr[RA_LSB +: RADDR_W];
        fld.rb       = instr[RB_LSB +: RADDR_W];
        fld.rc       = imm_form ? '0 : instr[RC_LSB +: RADDR_W];
        fld.imm      = imm_form ? instr[IMM_W-1:0] : '0;
        fld.imm_form = imm_form;
    end

    // Opcode class decode, at most one class per opcode.
    always_comb begin
        cls.reg_we   = (opc != '0) && !opc[OPC_W-1];
        cls.mem_we   = (opc == OP_STORE);
        cls.send     = (opc == OP_SEND);
        cls.recv     = (opc == OP_RECV);
        cls.flag_upd = (opc == OP_CMPF);
        cls.rloop    = (opc == OP_RLOOP);
    end
endmodule

// File: rtl/gpd_guard_eval.sv
// Module: gpd_guard_eval
// Holds the local condition flag and decides whether a word executes on
// this unit from its target bit, its guard bit and the current flag.
// Assumes flag writes come from the execution stage, one per cycle.
module gpd_guard_eval (
    input  logic clk,
    input  logic rst_n,
    input  logic role_pe,
    input  logic id_bit,
    input  logic g_bit,
    input  logic flag_wr_en,
    input  logic flag_wr_val,
    output logic exec_ok,
    output logic flag_q
);
    // Local flag register, written by the execution stage.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (flag_wr_en) flag_q <= flag_wr_val;
    end

    // Target match and guard rule against the pre-write flag.
    always_comb begin
        exec_ok = (id_bit == role_pe) && (g_bit || flag_q);
    end
endmodule

// File: rtl/gpd_lane_reduce.sv
// Module: gpd_lane_reduce
// Reduces per-lane pending and done bits into the receive-block exit test.
// Assumes the lane bits are already synchronous to clk.
module gpd_lane_reduce #(
    parameter int N_LANES = 8
) (
    input  logic [N_LANES-1:0] pend_vec,
    input  logic [N_LANES-1:0] done_vec,
    input  logic               sync_mode,
    output logic               exit_ok
);
    localparam int CHAIN = N_LANES + 1;

    logic [CHAIN-1:0] any_chain;
    logic [CHAIN-1:0] all_chain;

    assign any_chain[0] = 1'b0;
    assign all_chain[0] = 1'b1;

    // One OR and one AND stage per lane.
    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        assign any_chain[i+1] = any_chain[i] | pend_vec[i];
        assign all_chain[i+1] = all_chain[i] & done_vec[i];
    end

    // Exit needs no pending lane and, in sync mode, every lane done.
    always_comb begin
        exit_ok = !any_chain[N_LANES] && (!sync_mode || all_chain[N_LANES]);
    end
endmodule

// File: rtl/gpd_top.sv
// Module: gpd_top
// Guarded instruction predecoder: registers the field split, the execute
// decision, the class strobes and the receive-loop outcome with one cycle
// of latency. Assumes one word per cycle on instr when instr_valid is high.
module gpd_top
    import gpd_pkg::*;
#(
    parameter int N_LANES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 role_pe,
    input  logic                 instr_valid,
    input  logic [INSTR_W-1:0]   instr,
    input  logic                 flag_wr_en,
    input  logic                 flag_wr_val,
    input  logic [N_LANES-1:0]   pend_vec,
    input  logic [N_LANES-1:0]   done_vec,
    input  logic                 sync_mode,
    output logic                 dec_strobe,
    output logic                 dec_exec,
    output logic [OPC_W-1:0]     dec_opcode,
    output logic [RADDR_W-1:0]   dec_ra,
    output logic [RADDR_W-1:0]   dec_rb,
    output logic [RADDR_W-1:0]   dec_rc,
    output logic [IMM_W-1:0]     dec_imm,
    output logic                 dec_imm_form,
    output logic                 reg_we,
    output logic                 mem_we,
    output logic                 send_stb,
    output logic                 recv_stb,
    output logic                 flag_upd,
    output logic                 loop_repeat,
    output logic                 loop_exit,
    output logic                 flag_q
);
    fields_t fld;
    ctl_t    cls;
    logic    exec_ok;
    logic    exit_ok;
    logic    fire;
    logic    loop_hit;

    gpd_field_split u_split (
        .instr (instr),
        .fld   (fld),
        .cls   (cls)
    );

    gpd_guard_eval u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .role_pe     (role_pe),
        .id_bit      (fld.id),
        .g_bit       (fld.g),
        .flag_wr_en  (flag_wr_en),
        .flag_wr_val (flag_wr_val),
        .exec_ok     (exec_ok),
        .flag_q      (flag_q)
    );

    gpd_lane_reduce #(.N_LANES(N_LANES)) u_reduce (
        .pend_vec  (pend_vec),
        .done_vec  (done_vec),
        .sync_mode (sync_mode),
        .exit_ok   (exit_ok)
    );

    // Qualify execution with presence; the loop test runs on the control side only.
    always_comb begin
        fire     = instr_valid && exec_ok;
        loop_hit = fire && cls.rloop && !role_pe;
    end

    // Strobe, execute decision, class strobes and loop outcome, cleared on idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_strobe  <= 1'b0;
            dec_exec    <= 1'b0;
            reg_we      <= 1'b0;
            mem_we      <= 1'b0;
            send_stb    <= 1'b0;
            recv_stb    <= 1'b0;
            flag_upd    <= 1'b0;
            loop_repeat <= 1'b0;
            loop_exit   <= 1'b0;
        end else begin
            dec_strobe  <= instr_valid;
            dec_exec    <= fire;
            reg_we      <= fire && cls.reg_we;
            mem_we      <= fire && cls.mem_we;
            send_stb    <= fire && cls.send;
            recv_stb    <= fire && cls.recv;
            flag_upd    <= fire && cls.flag_upd;
            loop_repeat <= loop_hit && !exit_ok;
            loop_exit   <= loop_hit && exit_ok;
        end
    end

    // Field registers, loaded on each presented word and held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_opcode   <= '0;
            dec_ra       <= '0;
            dec_rb       <= '0;
            dec_rc       <= '0;
            dec_imm      <= '0;
            dec_imm_form <= 1'b0;
        end else if (instr_valid) begin
            dec_opcode   <= fld.opc;
            dec_ra       <= fld.ra;
            dec_rb       <= fld.rb;
            dec_rc       <= fld.rc;
            dec_imm      <= fld.imm;
            dec_imm_form <= fld.imm_form;
        end
    end
endmodule

// File: rtl/gpd_checker.sv
// Module: gpd_checker
// Protocol properties of the predecoder, attached to gpd_top by bind.
// Assumes the package layout for the target, guard and opcode positions.
module gpd_checker
    import gpd_pkg::*;
#(
    parameter int N_LANES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               role_pe,
    input logic               instr_valid,
    input logic [INSTR_W-1:0] instr,
    input logic [N_LANES-1:0] pend_vec,
    input logic               dec_strobe,
    input logic               dec_exec,
    input logic               reg_we,
    input logic               mem_we,
    input logic               send_stb,
    input logic               recv_stb,
    input logic               flag_upd,
    input logic               loop_repeat,
    input logic               loop_exit
);
    logic [4:0] cls_bits;
    assign cls_bits = {reg_we, mem_we, send_stb, recv_stb, flag_upd};

    a_r1_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> dec_strobe);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> (!dec_strobe && cls_bits == '0 && !loop_exit && !loop_repeat));

    a_r2_target_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && (instr[ID_BIT] != role_pe)) |=> !dec_exec);

    a_r3_guard_set_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && (instr[ID_BIT] == role_pe) && instr[G_BIT]) |=> dec_exec);

    a_r7_one_class: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cls_bits));

    a_r8_suppressed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_exec |-> (cls_bits == '0 && !loop_exit && !loop_repeat));

    a_r9_loop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(loop_exit && loop_repeat));

    a_r9_pending_repeats: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !role_pe && !instr[ID_BIT] && instr[G_BIT]
         && instr[OPC_LSB +: OPC_W] == OP_RLOOP && pend_vec != '0) |=> loop_repeat);
endmodule

bind gpd_top gpd_checker #(.N_LANES(N_LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .role_pe     (role_pe),
    .instr_valid (instr_valid),
    .instr       (instr),
    .pend_vec    (pend_vec),
    .dec_strobe  (dec_strobe),
    .dec_exec    (dec_exec),
    .reg_we      (reg_we),
    .mem_we      (mem_we),
    .send_stb    (send_stb),
    .recv_stb    (recv_stb),
    .flag_upd    (flag_upd),
    .loop_repeat (loop_repeat),
    .loop_exit   (loop_exit)
);

// File: tb/tb_gpd_top.sv
// Bench: tb_gpd_top
// Exhaustive sweep over role, target, guard, flag and opcode, plus a
// sweep of the receive-loop exit test; expectations are computed here.
module tb_gpd_top;
    localparam int CLK_PERIOD = 10;
    localparam int NL         = 8;
    localparam int WATCHDOG   = 200000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          role_pe;
    logic          instr_valid;
    logic [23:0]   instr;
    logic          flag_wr_en;
    logic          flag_wr_val;
    logic [NL-1:0] pend_vec;
    logic [NL-1:0] done_vec;
    logic          sync_mode;
    logic          dec_strobe, dec_exec, dec_imm_form;
    logic [5:0]    dec_opcode;
    logic [3:0]    dec_ra, dec_rb, dec_rc;
    logic [7:0]    dec_imm;
    logic          reg_we, mem_we, send_stb, recv_stb, flag_upd;
    logic          loop_repeat, loop_exit, flag_q;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpd_top #(.N_LANES(NL)) dut (
        .clk(clk), .rst_n(rst_n), .role_pe(role_pe), .instr_valid(instr_valid),
        .instr(instr), .flag_wr_en(flag_wr_en), .flag_wr_val(flag_wr_val),
        .pend_vec(pend_vec), .done_vec(done_vec), .sync_mode(sync_mode),
        .dec_strobe(dec_strobe), .dec_exec(dec_exec), .dec_opcode(dec_opcode),
        .dec_ra(dec_ra), .dec_rb(dec_rb), .dec_rc(dec_rc), .dec_imm(dec_imm),
        .dec_imm_form(dec_imm_form), .reg_we(reg_we), .mem_we(mem_we),
        .send_stb(send_stb), .recv_stb(recv_stb), .flag_upd(flag_upd),
        .loop_repeat(loop_repeat), .loop_exit(loop_exit), .flag_q(flag_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle writing the flag with no word present.
    task automatic write_flag(input logic v);
        flag_wr_en  = 1'b1;
        flag_wr_val = v;
        instr_valid = 1'b0;
        @(negedge clk);
        flag_wr_en  = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; role_pe = 1'b0; instr_valid = 1'b0; instr = '0;
        flag_wr_en = 1'b0; flag_wr_val = 1'b0; pend_vec = '0; done_vec = '1;
        sync_mode = 1'b0;
        repeat (3) @(negedge clk);
        // R10: outputs low during reset
        chk("R10 strobes", {dec_strobe, dec_exec, reg_we, mem_we, send_stb, recv_stb,
                            flag_upd, loop_repeat, loop_exit, flag_q}, 32'h0);
        chk("R10 fields", {dec_opcode, dec_ra, dec_rb, dec_rc, dec_imm, dec_imm_form}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 after release", {dec_strobe, loop_exit, flag_q}, 32'h0);

        // Main sweep: role x flag x target x guard x opcode.
        for (int role = 0; role < 2; role++) begin
            for (int fl = 0; fl < 2; fl++) begin
                for (int idb = 0; idb < 2; idb++) begin
                    for (int gb = 0; gb < 2; gb++) begin
                        for (int op = 0; op < 64; op++) begin
                            logic [15:0] low;
                            logic        ex, imf;
                            logic [7:0]  eimm;
                            logic [3:0]  erc;
                            logic [4:0]  ecls;
                            logic        eexit;
                            low = 16'(op * 16'h9E37 + role * 16'h1357 + fl * 16'h0F0F + 16'h2468);
                            role_pe = role[0];
                            write_flag(fl[0]);
                            chk("R4 flag_q", {31'h0, flag_q}, {31'h0, fl[0]});
                            instr = {idb[0], gb[0], op[5:0], low};
                            instr_valid = 1'b1;
                            @(negedge clk);
                            instr_valid = 1'b0;
                            ex   = (idb[0] == role[0]) && (gb[0] || fl[0]);
                            imf  = (op >= 16 && op < 32);
                            eimm = imf ? low[7:0] : 8'h0;
                            erc  = imf ? 4'h0 : low[7:4];
                            ecls = {ex && op >= 1 && op < 32, ex && op == 32, ex && op == 33,
                                    ex && op == 34, ex && op == 35};
                            eexit = ex && op == 48 && role == 0;
                            chk("R1 strobe", {31'h0, dec_strobe}, 32'h1);
                            chk("R2/R3 exec", {31'h0, dec_exec}, {31'h0, ex});
                            chk("R5 fields", {dec_opcode, dec_ra, dec_rb},
                                {op[5:0], low[15:12], low[11:8]});
                            chk("R6 imm", {dec_imm_form, erc == dec_rc, dec_imm},
                                {imf, 1'b1, eimm});
                            chk(ex ? "R7 class" : "R8 suppressed",
                                {reg_we, mem_we, send_stb, recv_stb, flag_upd}, ecls);
                            chk("R9 loop", {loop_repeat, loop_exit}, {1'b0, eexit});
                        end
                    end
                end
            end
        end

        // R1: idle cycle clears strobes
        @(negedge clk);
        chk("R1 idle", {dec_strobe, reg_we, mem_we, send_stb, recv_stb, flag_upd,
                        loop_repeat, loop_exit}, 32'h0);

        // R4: same-cycle flag write is not seen by the word, next word sees it.
        role_pe = 1'b1;
        write_flag(1'b0);
        flag_wr_en = 1'b1; flag_wr_val = 1'b1;
        instr = {1'b1, 1'b0, 6'h05, 16'h1230};
        instr_valid = 1'b1;
        @(negedge clk);
        flag_wr_en = 1'b0;
        chk("R4 same-cycle old flag", {dec_exec, reg_we}, 2'b00);
        @(negedge clk);
        instr_valid = 1'b0;
        chk("R4 next word new flag", {dec_exec, reg_we}, 2'b11);

        // R9: loop-exit sweep on the control side.
        role_pe = 1'b0;
        for (int p = 0; p <= NL; p++) begin
            for (int d = 0; d <= NL; d++) begin
                for (int s = 0; s < 2; s++) begin
                    logic eexit;
                    pend_vec  = (p == 0) ? '0 : NL'(1) << (p - 1);
                    done_vec  = (d == 0) ? '1 : ~(NL'(1) << (d - 1));
                    sync_mode = s[0];
                    instr = {1'b0, 1'b1, 6'h30, 16'h0};
                    instr_valid = 1'b1;
                    @(negedge clk);
                    instr_valid = 1'b0;
                    eexit = (p == 0) && (s == 0 || d == 0);
                    chk("R9 exit test", {loop_repeat, loop_exit}, {!eexit, eexit});
                end
            end
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule